// File: doc/BRIEF.md
# Port Statistics Snapshot Reader

This block fetches the hardware statistics counters of one switch port over a simple register-access port. On a request it names the port, and the switch freezes that port's counters through a snapshot command. The block then walks a caller-supplied list of counter entries. Each entry gives a counter index and a flag that says whether the counter is 32 or 64 bits wide. For every entry the block produces one output record: the index and the assembled 64-bit value.

Each 32-bit half is read the same way. The block writes a select command into the command/status register and polls the busy bit until it clears. It then reads the upper and lower 16-bit data registers. A wide counter takes two such reads, at the entry's index and at the index after it. A poll that never clears costs only the half it belongs to, except for the snapshot: if the snapshot never completes, the request ends with an error and no counter is read.

The list itself sits outside the block. The block presents an entry pointer, and the surrounding logic answers with that entry's index and width on the same cycle.

Top module: `stsnap_reader`

## Requirements
- R1: The first register transaction after an accepted request is a write to address 0x1D with data 0xDC00 OR the port number (port in the low bits).
- R2: After every command write, the block reads address 0x1D until bit 15 of the returned data is 0. It stops after POLL_LIMIT (default 10) reads that all return bit 15 set.
- R3: If the snapshot poll runs out, `done` pulses with `done_err` = 1. No `out_valid` is given and no further register transaction is made for that request.
- R4: Reading one 32-bit half writes address 0x1D with data 0xCC00 OR the counter index (index in the low IDX_W bits).
- R5: Once a select poll finds bit 15 clear, the block reads address 0x1E and then address 0x1F. The half's value is {data of 0x1E, data of 0x1F}.
- R6: A 32-bit entry uses exactly one select command, and bits 63:32 of its output value are 0.
- R7: A 64-bit entry reads index n into bits 31:0 and then index n+1 into bits 63:32, low half first. The index n+1 wraps modulo 2^IDX_W.
- R8: If a select poll runs out, that half is reported as 0 and no data register is read for it. The other half and the following entries are read normally.
- R9: There is one single-cycle `out_valid` per entry, in list order, with `out_idx` equal to the entry's index. After the last entry, a single-cycle `done` follows with `done_err` = 0.
- R10: A request with `req_count` = 0 performs only the snapshot command and its poll, then pulses `done` with no output record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a read-out; taken when `req_ready` is high |
| req_port | input | PORT_W (4) | Port whose counters are captured |
| req_count | input | CNT_W (4) | Number of list entries, 0 to MAX_LIST |
| req_ready | output | 1 | Block is idle and accepts a request |
| ent_sel | output | SEL_W (3) | Pointer to the current list entry |
| ent_idx | input | IDX_W (6) | Counter index of the entry at `ent_sel` |
| ent_wide | input | 1 | Entry at `ent_sel` is a 64-bit counter |
| reg_req | output | 1 | Register transaction pending; held until `reg_ack` |
| reg_wr | output | 1 | Pending transaction is a write |
| reg_addr | output | 5 | Register address |
| reg_wdata | output | 16 | Write data |
| reg_ack | input | 1 | Transaction complete (one cycle) |
| reg_rdata | input | 16 | Read data, valid with `reg_ack` |
| out_valid | output | 1 | One counter value is presented |
| out_idx | output | IDX_W (6) | Index of the presented counter |
| out_value | output | 64 | Assembled counter value |
| done | output | 1 | End of the request (one cycle) |
| done_err | output | 1 | Snapshot timed out; valid with `done` |

## Verification
The assertions assume the following about the inputs:
- `ent_idx` and `ent_wide` depend only on `ent_sel`, so they hold steady for a whole entry.
- `req_count` never exceeds MAX_LIST.
- `reg_ack` comes only while `reg_req` is high, for one cycle, with `reg_rdata` valid in that cycle.

The bench meets these terms directly. The list is a table indexed by `ent_sel`, counts stay at or below eight, and the switch model raises the acknowledge for one cycle, only in answer to a pending request and never in the cycle right after a previous acknowledge. Busy lengths are chosen per command, including exactly the limit and beyond it, so every poll outcome is reached.

// File: rtl/stsnap_pkg.sv
// Shared constants and state encoding for the statistics snapshot reader.
// Assumes the switch exposes a command/status register with a busy flag in
// bit 15 and two 16-bit data registers holding one 32-bit counter half.
package stsnap_pkg;

    localparam logic [4:0]  ADDR_CMD  = 5'h1D;
    localparam logic [4:0]  ADDR_HI   = 5'h1E;
    localparam logic [4:0]  ADDR_LO   = 5'h1F;
    localparam logic [15:0] OP_SNAP   = 16'hDC00;
    localparam logic [15:0] OP_SELECT = 16'hCC00;
    localparam int          BUSY_BIT  = 15;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SNAP_WR,
        ST_SNAP_POLL,
        ST_SEL_WR,
        ST_SEL_POLL,
        ST_RD_HI,
        ST_RD_LO,
        ST_EMIT,
        ST_FINISH
    } stsnap_state_t;

endpackage

// File: rtl/stsnap_poll.sv
// Busy-poll counter: counts busy answers since the last command write and
// flags the final permitted poll. Assumes bump is never given while last is
// high (the sequencer ends the wait instead).
module stsnap_poll #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Count busy answers; restart on every command write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (bump)
            cnt_q <= cnt_q + 1'b1;
    end

    // Current poll is the last one allowed.
    assign last = (cnt_q == CW'(LIMIT - 1));

    a_r2_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));

endmodule

// File: rtl/stsnap_accum.sv
// Value assembler: builds a 64-bit counter value from 16-bit data reads,
// one 32-bit half at a time. A cleared half stays zero if it is never loaded.
module stsnap_accum (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        ld_hi,
    input  logic        ld_lo,
    input  logic        upper,
    input  logic [15:0] din,
    output logic [63:0] value
);
    logic [1:0][31:0] acc_q;

    // Clear between entries, then load the selected half's 16-bit pieces.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            acc_q <= '0;
        else if (ld_hi)
            acc_q[upper][31:16] <= din;
        else if (ld_lo)
            acc_q[upper][15:0] <= din;
    end

    assign value = acc_q;

    a_r5_one_load: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hi && ld_lo));

endmodule

// File: rtl/stsnap_reader.sv
// Statistics snapshot reader top. Captures one port's counters with a
// snapshot command, then reads each list entry (32 or 64 bits) through the
// select/poll/data-read sequence and streams index + value records.
// Assumes: ent_idx/ent_wide depend only on ent_sel; req_count <= MAX_LIST;
// reg_ack is a single-cycle answer to a pending reg_req; PORT_W, IDX_W <= 10.
module stsnap_reader
    import stsnap_pkg::*;
#(
    parameter int PORT_W     = 4,
    parameter int IDX_W      = 6,
    parameter int MAX_LIST   = 8,
    parameter int POLL_LIMIT = 10,
    localparam int SEL_W     = (MAX_LIST > 1) ? $clog2(MAX_LIST) : 1,
    localparam int CNT_W     = $clog2(MAX_LIST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PORT_W-1:0] req_port,
    input  logic [CNT_W-1:0]  req_count,
    output logic              req_ready,
    output logic [SEL_W-1:0]  ent_sel,
    input  logic [IDX_W-1:0]  ent_idx,
    input  logic              ent_wide,
    output logic              reg_req,
    output logic              reg_wr,
    output logic [4:0]        reg_addr,
    output logic [15:0]       reg_wdata,
    input  logic              reg_ack,
    input  logic [15:0]       reg_rdata,
    output logic [IDX_W-1:0]  out_idx,
    output logic              out_valid,
    output logic [63:0]       out_value,
    output logic              done,
    output logic              done_err
);
    stsnap_state_t     state_q;
    logic [PORT_W-1:0] port_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  ptr_q;
    logic              half_q;
    logic              err_q;

    logic              busy;
    logic              poll_last;
    logic              poll_clr;
    logic              poll_bump;
    logic              acc_clr;
    logic              ld_hi;
    logic              ld_lo;
    logic              in_poll;
    logic [IDX_W-1:0]  cur_idx;
    logic              more_half;

    // Decode bus-side and handshake signals from the current state.
    always_comb begin
        in_poll   = (state_q == ST_SNAP_POLL) || (state_q == ST_SEL_POLL);
        busy      = reg_rdata[BUSY_BIT];
        cur_idx   = ent_idx + IDX_W'(half_q);
        more_half = ent_wide && !half_q;
        reg_req   = (state_q == ST_SNAP_WR) || (state_q == ST_SEL_WR) ||
                    in_poll || (state_q == ST_RD_HI) || (state_q == ST_RD_LO);
        reg_wr    = (state_q == ST_SNAP_WR) || (state_q == ST_SEL_WR);
        case (state_q)
            ST_RD_HI: reg_addr = ADDR_HI;
            ST_RD_LO: reg_addr = ADDR_LO;
            default:  reg_addr = ADDR_CMD;
        endcase
        case (state_q)
            ST_SNAP_WR: reg_wdata = OP_SNAP | 16'(port_q);
            ST_SEL_WR:  reg_wdata = OP_SELECT | 16'(cur_idx);
            default:    reg_wdata = '0;
        endcase
        poll_clr  = reg_ack && reg_wr;
        poll_bump = reg_ack && in_poll && busy && !poll_last;
        acc_clr   = (state_q == ST_IDLE) || (state_q == ST_EMIT);
        ld_hi     = reg_ack && (state_q == ST_RD_HI);
        ld_lo     = reg_ack && (state_q == ST_RD_LO);
    end

    // Sequencer: snapshot, then per entry one or two select/poll/read halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            port_q  <= '0;
            count_q <= '0;
            ptr_q   <= '0;
            half_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    port_q  <= req_port;
                    count_q <= req_count;
                    ptr_q   <= '0;
                    half_q  <= 1'b0;
                    err_q   <= 1'b0;
                    state_q <= ST_SNAP_WR;
                end
                ST_SNAP_WR: if (reg_ack) state_q <= ST_SNAP_POLL;
                ST_SNAP_POLL: if (reg_ack) begin
                    if (!busy)
                        state_q <= (count_q == '0) ? ST_FINISH : ST_SEL_WR;
                    else if (poll_last) begin
                        err_q   <= 1'b1;
                        state_q <= ST_FINISH;
                    end
                end
                ST_SEL_WR: if (reg_ack) state_q <= ST_SEL_POLL;
                ST_SEL_POLL: if (reg_ack) begin
                    if (!busy)
                        state_q <= ST_RD_HI;
                    else if (poll_last) begin
                        half_q  <= more_half;
                        state_q <= more_half ? ST_SEL_WR : ST_EMIT;
                    end
                end
                ST_RD_HI: if (reg_ack) state_q <= ST_RD_LO;
                ST_RD_LO: if (reg_ack) begin
                    half_q  <= more_half;
                    state_q <= more_half ? ST_SEL_WR : ST_EMIT;
                end
                ST_EMIT: begin
                    half_q  <= 1'b0;
                    ptr_q   <= ptr_q + 1'b1;
                    state_q <= (ptr_q + 1'b1 == count_q) ? ST_FINISH : ST_SEL_WR;
                end
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    stsnap_poll #(.LIMIT(POLL_LIMIT)) i_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (poll_clr),
        .bump  (poll_bump),
        .last  (poll_last)
    );

    stsnap_accum i_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .ld_hi (ld_hi),
        .ld_lo (ld_lo),
        .upper (half_q),
        .din   (reg_rdata),
        .value (out_value)
    );

    // Present the entry pointer, the output record and the completion pulse.
    assign ent_sel   = ptr_q[SEL_W-1:0];
    assign req_ready = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_EMIT);
    assign out_idx   = ent_idx;
    assign done      = (state_q == ST_FINISH);
    assign done_err  = err_q;

    a_r1_snap_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (reg_req && reg_wr && reg_addr == ADDR_CMD &&
                                      reg_wdata == (OP_SNAP | 16'($past(req_port)))));

    a_r4_write_target: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_wr) |-> (reg_addr == ADDR_CMD));

    a_r5_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) &&
                                   $stable(reg_wr) && $stable(reg_wdata)));

    a_r3_timeout_err: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SNAP_POLL && reg_ack && busy && poll_last) |=> (done && done_err));

    a_r6_narrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !ent_wide) |-> (out_value[63:32] == 32'h0));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && (done || reg_req)));

endmodule

// File: tb/test_stsnap_reader.sv
`timescale 1ns/1ps
module test_stsnap_reader;
    localparam int PORT_W = 4;
    localparam int IDX_W  = 6;
    localparam int NLIST  = 8;
    localparam int LIM    = 10;

    typedef struct { bit wr; logic [4:0] a; logic [15:0] d; string tag; } txn_t;
    typedef struct { int idx; logic [63:0] v; string tag; } rec_t;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0;
    logic [PORT_W-1:0] req_port = '0;
    logic [3:0] req_count = '0;
    logic req_ready, reg_req, reg_wr, reg_ack, out_valid, done, done_err, ent_wide;
    logic [2:0] ent_sel;
    logic [IDX_W-1:0] ent_idx, out_idx;
    logic [4:0] reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic [63:0] out_value;

    int tab_idx [NLIST];
    bit tab_wide [NLIST];
    assign ent_idx  = IDX_W'(tab_idx[ent_sel]);
    assign ent_wide = tab_wide[ent_sel];

    stsnap_reader i_stsnap_reader (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
        .req_count(req_count), .req_ready(req_ready), .ent_sel(ent_sel),
        .ent_idx(ent_idx), .ent_wide(ent_wide), .reg_req(reg_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
        .reg_rdata(reg_rdata), .out_idx(out_idx), .out_valid(out_valid),
        .out_value(out_value), .done(done), .done_err(done_err)
    );

    always #4 clk = ~clk;

    int nvec = 0, nbad = 0;
    txn_t exp_t[$];
    rec_t exp_o[$];
    int busyq[$];
    bit exp_err, got_done;
    int m_port, m_idx, m_busy;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cval(input int p, input int i);
        return (32'(p) << 24) ^ (32'(i) * 32'h0001_0203) ^ 32'hA5C3_1E70;
    endfunction

    task automatic push_t(input bit wr, input logic [4:0] a, input logic [15:0] d, input string tag);
        txn_t t;
        t.wr = wr; t.a = a; t.d = d; t.tag = tag;
        exp_t.push_back(t);
    endtask

    // Expected bus traffic for one half; returns the expected half value.
    task automatic plan_half(input int port, input int idx, inout int bq[$], output logic [31:0] v);
        int b;
        push_t(1, 5'h1D, 16'hCC00 | 16'(idx), "R4");
        b = (bq.size() != 0) ? bq.pop_front() : 0;
        if (b >= LIM) begin
            repeat (LIM) push_t(0, 5'h1D, 0, "R8");
            v = '0;
        end else begin
            repeat (b + 1) push_t(0, 5'h1D, 0, "R2");
            push_t(0, 5'h1E, 0, "R5");
            push_t(0, 5'h1F, 0, "R5");
            v = cval(port, idx);
        end
    endtask

    task automatic run(input int port, input int n, input int busy[$], input bit fail_case);
        int bq[$];
        int b;
        logic [31:0] lo, hi;
        rec_t r;
        bq = busy;
        busyq = busy;
        push_t(1, 5'h1D, 16'hDC00 | 16'(port), "R1");
        b = (bq.size() != 0) ? bq.pop_front() : 0;
        if (b >= LIM) begin
            repeat (LIM) push_t(0, 5'h1D, 0, "R3");
            exp_err = 1;
        end else begin
            repeat (b + 1) push_t(0, 5'h1D, 0, "R2");
            exp_err = 0;
            for (int k = 0; k < n; k++) begin
                plan_half(port, tab_idx[k], bq, lo);
                hi = '0;
                if (tab_wide[k]) plan_half(port, (tab_idx[k] + 1) % (1 << IDX_W), bq, hi);
                r.idx = tab_idx[k];
                r.v = {hi, lo};
                r.tag = fail_case ? "R8" : (tab_wide[k] ? "R7" : "R6");
                exp_o.push_back(r);
            end
        end
        got_done = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_port = PORT_W'(port); req_count = 4'(n);
        @(negedge clk);
        req_valid = 0;
        while (!got_done) @(negedge clk);
        chk(exp_t.size() == 0, "R3", 64'(exp_t.size()), 0);
        chk(exp_o.size() == 0, "R9", 64'(exp_o.size()), 0);
        exp_t.delete();
        exp_o.delete();
    endtask

    // Switch model: answers each pending transaction one cycle later.
    initial begin
        reg_ack = 0; reg_rdata = '0;
        m_port = 0; m_idx = 0; m_busy = 0;
        forever begin
            @(negedge clk);
            if (reg_ack) begin
                reg_ack = 0;
            end else if (rst_n && reg_req) begin
                if (exp_t.size() == 0) begin
                    chk(0, "R3", {reg_wr, reg_addr, reg_wdata}, 0);
                end else begin
                    txn_t e;
                    e = exp_t.pop_front();
                    chk(reg_wr == e.wr && reg_addr == e.a && (!e.wr || reg_wdata == e.d),
                        e.tag, {reg_wr, reg_addr, reg_wdata}, {e.wr, e.a, e.d});
                end
                reg_rdata = '0;
                if (reg_wr) begin
                    if (reg_wdata[15:10] == 6'b110111) m_port = int'(reg_wdata[PORT_W-1:0]);
                    else m_idx = int'(reg_wdata[IDX_W-1:0]);
                    m_busy = (busyq.size() != 0) ? busyq.pop_front() : 0;
                end else if (reg_addr == 5'h1D) begin
                    if (m_busy > 0) begin
                        reg_rdata = 16'h8000;
                        m_busy--;
                    end
                end else if (reg_addr == 5'h1E) begin
                    reg_rdata = cval(m_port, m_idx)[31:16];
                end else begin
                    reg_rdata = cval(m_port, m_idx)[15:0];
                end
                reg_ack = 1;
            end
        end
    end

    // Output monitor: compares records and completion against expectations.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (exp_o.size() == 0) chk(0, "R9", out_value, 0);
                else begin
                    rec_t r;
                    r = exp_o.pop_front();
                    chk(int'(out_idx) == r.idx, "R9", 64'(out_idx), 64'(r.idx));
                    chk(out_value == r.v, r.tag, out_value, r.v);
                end
            end
            if (rst_n && done) begin
                chk(done_err == exp_err, exp_err ? "R3" : "R9", 64'(done_err), 64'(exp_err));
                got_done = 1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !reg_req && !out_valid && !done, "R9",
            {req_ready, reg_req, out_valid, done}, 4'b1000);
        rst_n = 1;
        // R6 R7: mixed list, no busy
        tab_idx[0] = 4;  tab_wide[0] = 0;
        tab_idx[1] = 9;  tab_wide[1] = 1;
        run(3, 2, '{0, 0, 0, 0}, 0);
        // R2: assorted busy lengths, longest allowed is LIM-1
        tab_idx[0] = 1;  tab_wide[0] = 1;
        tab_idx[1] = 2;  tab_wide[1] = 0;
        tab_idx[2] = 7;  tab_wide[2] = 0;
        run(5, 3, '{3, 9, 1, 5, 0}, 0);
        // R3: snapshot busy exactly the limit
        tab_idx[0] = 1;  tab_wide[0] = 0;
        run(2, 1, '{10}, 0);
        // R8: failing halves
        tab_idx[0] = 10; tab_wide[0] = 1;
        tab_idx[1] = 11; tab_wide[1] = 0;
        tab_idx[2] = 12; tab_wide[2] = 1;
        run(6, 3, '{0, 10, 0, 15, 2, 10}, 1);
        // R10: empty list
        run(1, 0, '{4}, 0);
        // R7: index wrap on wide counter
        tab_idx[0] = 63; tab_wide[0] = 1;
        run(15, 1, '{0, 0, 0}, 0);
        // R9: full list
        for (int k = 0; k < NLIST; k++) begin
            tab_idx[k] = 20 + 3 * k;
            tab_wide[k] = k[0];
        end
        run(0, NLIST, '{0}, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule